// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

The block gathers eight interrupt request lines, keeps the requests it has latched, hides the inputs the mask disables and picks the winner by fixed rank (input 0 first). It raises `int_o` toward the processor or toward an upstream controller. An acknowledge pulse moves the winner into the in-service set and presents an 8-bit vector. A later end-of-interrupt command frees the in-service entry. Several instances can be chained: the `int_o` of a downstream instance feeds one input of an upstream instance, and the upstream one marks those inputs so that it leaves the vector to the downstream part.

Software programs the block through a two-address write port. A write to the even address with data bit 4 set restarts setup. It chooses single or chained operation (bit 1: 1 = single, 0 = chained), level or edge requests (bit 3: 1 = level, 0 = edge), and whether a final mode word follows (bit 0). The next odd write is the vector base. In chained mode an odd write carrying the chain word follows. When a mode word was announced, it comes last, and its bit 1 turns on automatic end-of-interrupt. After setup every odd write loads the mask. Even writes of 0x20 are end-of-interrupt commands. The `master_i` pin picks the upstream role.

Top module: `irq_ctrl`

## Requirements
- R1: After reset `int_o`, `vec_o` and `vec_en_o` are 0, and no request line can raise `int_o` until setup has completed.
- R2: An even write with bit 4 set starts setup and clears mask, in-service and request state. Setup words are then taken from odd writes in this order: base, chain word (only if bit 1 was 0), mode word (only if bit 0 was 1). `int_o` stays low until the last expected word has been written.
- R3: The vector presented after an acknowledge equals base + winning input index, and it is valid from the first clock edge after the acknowledge.
- R4: In chained mode with `master_i` = 1, an acknowledge whose winner has its bit set in the chain word drives `vec_en_o` low; every other acknowledge drives it high.
- R5: The mode word is consumed only when announced. Its bit 1 = 1 selects automatic end-of-interrupt. Without a mode word, normal end-of-interrupt applies.
- R6: Odd writes after setup load the mask, and a set bit disables that input; a masked request stays latched and is served once unmasked. Setup words never load the mask.
- R7: Among unmasked pending requests the lowest index wins.
- R8: In edge mode a request is latched on a rising input. It is cleared by its acknowledge, and an input held high does not request again until it falls and rises.
- R9: In level mode the request follows the input level on each clock.
- R10: `int_o` is high only when the winning request ranks strictly above every in-service input.
- R11: An acknowledge while `int_o` is high sets the winner's in-service bit and clears its request. An acknowledge while `int_o` is low presents base + 7 and changes no state.
- R12: An even write of 0x20 after setup clears the highest-ranked in-service bit. Other even writes with bit 4 clear have no effect.
- R13: In automatic end-of-interrupt mode an acknowledge leaves no in-service bit set, so a higher or equal input can interrupt again at once.
- R14: When an acknowledge and an end-of-interrupt fall in the same cycle, the end-of-interrupt acts on the in-service set as it stood before that cycle, and the acknowledged input is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe, one cycle per write |
| a0_i | input | 1 | Address select: 0 even, 1 odd |
| wdata_i | input | 8 | Write data |
| master_i | input | 1 | 1 = upstream role in a chain |
| irq_i | input | 8 | Request lines, input 0 highest rank |
| ack_i | input | 1 | Acknowledge pulse, one cycle |
| int_o | output | 1 | Interrupt request to the processor or upstream controller |
| vec_o | output | 8 | Vector of the last acknowledge |
| vec_en_o | output | 1 | 1 when this instance supplies the vector of the last acknowledge |

## Verification
An acknowledge and an end-of-interrupt command can land on the same clock edge. Both update the in-service set, and the outcome depends on which of the two sees the other's result. The bench places input 4 in service, raises input 2, and then drives `ack_i` together with an even write of 0x20 in one cycle. It then raises input 5: `int_o` must stay low while input 2 is in service, and must rise after one more end-of-interrupt. That second step only happens if input 4 was already freed by the shared cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_BASE,
    ST_CHAIN,
    ST_MODE,
    ST_RUN
  } setup_st_e;

  localparam logic [7:0] EOI_CMD   = 8'h20;
  localparam int         B_START   = 4;
  localparam int         B_LEVEL   = 3;
  localparam int         B_SINGLE  = 1;
  localparam int         B_HASMODE = 0;
  localparam int         B_AUTOEOI = 1;
endpackage

// File: rtl/irq_ctrl_cfg.sv
module irq_ctrl_cfg
  import irq_ctrl_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          init_o,
  output logic          eoi_o,
  output logic [DW-1:0] base_o,
  output logic [N-1:0]  chain_o,
  output logic [N-1:0]  mask_o,
  output logic          level_o,
  output logic          single_o,
  output logic          aeoi_o
);
  setup_st_e st_q;
  logic      has_mode_q;
  logic      odd_wr;

  assign init_o  = wr_i && !a0_i && wdata_i[B_START];
  assign odd_wr  = wr_i && a0_i;
  assign ready_o = (st_q == ST_RUN);
  assign eoi_o   = wr_i && !a0_i && ready_o && (wdata_i == EOI_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_OFF;
      has_mode_q <= 1'b0;
      base_o     <= '0;
      chain_o    <= '0;
      mask_o     <= '0;
      level_o    <= 1'b0;
      single_o   <= 1'b0;
      aeoi_o     <= 1'b0;
    end else if (init_o) begin
      st_q       <= ST_BASE;
      has_mode_q <= wdata_i[B_HASMODE];
      level_o    <= wdata_i[B_LEVEL];
      single_o   <= wdata_i[B_SINGLE];
      aeoi_o     <= 1'b0;
      chain_o    <= '0;
      mask_o     <= '0;
    end else if (odd_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base_o <= wdata_i;
          if (!single_o)       st_q <= ST_CHAIN;
          else if (has_mode_q) st_q <= ST_MODE;
          else                 st_q <= ST_RUN;
        end
        ST_CHAIN: begin
          chain_o <= wdata_i[N-1:0];
          st_q    <= has_mode_q ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          aeoi_o <= wdata_i[B_AUTOEOI];
          st_q   <= ST_RUN;
        end
        ST_RUN:  mask_o <= wdata_i[N-1:0];
        default: ;
      endcase
    end
  end

  // R6
  mask_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_o && !(odd_wr && ready_o)) |=> $stable(mask_o));
  // R2
  seq_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_wr && !init_o && st_q == ST_BASE) |=> (st_q != ST_BASE));
endmodule

// File: rtl/irq_ctrl_req.sv
module irq_ctrl_req #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         ready_i,
  input  logic         init_i,
  input  logic         level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= irq_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     irr_o[g] <= 1'b0;
      else if (init_i || !ready_i)     irr_o[g] <= 1'b0;
      else if (level_i)                irr_o[g] <= irq_i[g];
      else if (irq_i[g] && !prev_q[g]) irr_o[g] <= 1'b1;
      else if (clr_i[g])               irr_o[g] <= 1'b0;
    end
  end

  // R8
  edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !level_i && !init_i) |=>
      ((irr_o & ~$past(irr_o) & ~$past(irq_i & ~prev_q)) == '0));
endmodule

// File: rtl/irq_ctrl_svc.sv
module irq_ctrl_svc #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic          init_i,
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  mask_i,
  input  logic [DW-1:0] base_i,
  input  logic [N-1:0]  chain_i,
  input  logic          master_i,
  input  logic          single_i,
  input  logic          aeoi_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  output logic          int_o,
  output logic [DW-1:0] vec_o,
  output logic          vec_en_o,
  output logic [N-1:0]  clr_o
);
  localparam int IW = $clog2(N);
  localparam logic [DW-1:0] LAST = DW'(N - 1);
  localparam logic [N-1:0]  ONE  = {{(N-1){1'b0}}, 1'b1};

  function automatic logic [IW-1:0] top_idx(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  logic [N-1:0]  isr_q, pend, win_oh, eoi_oh;
  logic [IW-1:0] win, isr_top;
  logic          fire;

  assign pend    = irr_i & ~mask_i;
  assign win     = top_idx(pend);
  assign isr_top = top_idx(isr_q);
  assign win_oh  = ONE << win;
  assign eoi_oh  = ONE << isr_top;
  assign int_o   = ready_i && (|pend) && (!(|isr_q) || (win < isr_top));
  assign fire    = ack_i && int_o;
  assign clr_o   = fire ? win_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     isr_q <= '0;
    else if (init_i) isr_q <= '0;
    else isr_q <= (isr_q & ~(eoi_i ? eoi_oh : '0)) |
                  ((fire && !aeoi_i) ? win_oh : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o    <= '0;
      vec_en_o <= 1'b0;
    end else if (ack_i) begin
      vec_o    <= fire ? (base_i + DW'(win)) : (base_i + LAST);
      vec_en_o <= !(fire && master_i && !single_i && chain_i[win]);
    end
  end

  // R1
  int_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> !int_o);
  // R6
  int_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr_i & ~mask_i));
  // R13
  aeoi_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aeoi_i && ready_i) |-> (isr_q == '0));
  // R12
  eoi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !fire && isr_q != '0) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));
  // R11
  ack_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !aeoi_i && !eoi_i) |=> (isr_q != '0));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            a0_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            master_i,
  input  logic [N_IN-1:0] irq_i,
  input  logic            ack_i,
  output logic            int_o,
  output logic [DW-1:0]   vec_o,
  output logic            vec_en_o
);
  logic            ready, init, eoi, level, single, aeoi;
  logic [DW-1:0]   base;
  logic [N_IN-1:0] chain, mask, irr, clr;

  irq_ctrl_cfg #(.N(N_IN), .DW(DW)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .a0_i, .wdata_i,
    .ready_o(ready), .init_o(init), .eoi_o(eoi), .base_o(base),
    .chain_o(chain), .mask_o(mask), .level_o(level),
    .single_o(single), .aeoi_o(aeoi)
  );

  irq_ctrl_req #(.N(N_IN)) u_req (
    .clk_i, .rst_ni, .irq_i, .ready_i(ready), .init_i(init),
    .level_i(level), .clr_i(clr), .irr_o(irr)
  );

  irq_ctrl_svc #(.N(N_IN), .DW(DW)) u_svc (
    .clk_i, .rst_ni, .ready_i(ready), .init_i(init), .irr_i(irr),
    .mask_i(mask), .base_i(base), .chain_i(chain), .master_i,
    .single_i(single), .aeoi_i(aeoi), .ack_i, .eoi_i(eoi),
    .int_o, .vec_o, .vec_en_o, .clr_o(clr)
  );
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, a0 = 1'b0, master = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq = '0;
  logic       int_w, vec_en;
  logic [7:0] vec;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .a0_i(a0), .wdata_i(wdata),
    .master_i(master), .irq_i(irq), .ack_i(ack), .int_o(int_w),
    .vec_o(vec), .vec_en_o(vec_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic adr, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; a0 = adr; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic eoi; wr_reg(1'b0, 8'h20); endtask

  task automatic t_reset;
    chk("R1 int", {7'b0, int_w}, 8'h0);
    chk("R1 vec", vec, 8'h00);
    chk("R1 vec_en", {7'b0, vec_en}, 8'h0);
    set_irq(8'h01);
    chk("R1 no int before setup", {7'b0, int_w}, 8'h0);
    set_irq(8'h00);
  endtask

  task automatic t_setup_single;
    wr_reg(1'b0, 8'h13);
    wr_reg(1'b1, 8'h30);
    chk("R2 int low mid setup", {7'b0, int_w}, 8'h0);
    wr_reg(1'b1, 8'h01);
    wr_reg(1'b1, 8'h00);
    set_irq(8'h08);
    chk("R2 R8 edge latched", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R3 vector base+3", vec, 8'h33);
    chk("R11 int drops after ack", {7'b0, int_w}, 8'h0);
  endtask

  task automatic t_nesting;
    set_irq(8'h28);
    chk("R10 lower rank blocked", {7'b0, int_w}, 8'h0);
    set_irq(8'h2A);
    chk("R7 R10 higher rank nests", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R3 vector 1", vec, 8'h31);
    eoi;
    chk("R12 eoi frees 1 only", {7'b0, int_w}, 8'h0);
    eoi;
    chk("R12 eoi frees 3", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R3 vector 5", vec, 8'h35);
    wr_reg(1'b0, 8'h0B);
    set_irq(8'h6A);
    chk("R12 other even write ignored", {7'b0, int_w}, 8'h0);
    eoi;
    chk("R12 eoi frees 5", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R3 vector 6", vec, 8'h36);
    eoi;
    set_irq(8'h00);
  endtask

  task automatic t_mask;
    wr_reg(1'b1, 8'h04);
    set_irq(8'h04);
    chk("R6 masked input", {7'b0, int_w}, 8'h0);
    set_irq(8'h14);
    chk("R6 unmasked input", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R6 vector 4", vec, 8'h34);
    eoi;
    chk("R6 still masked", {7'b0, int_w}, 8'h0);
    wr_reg(1'b1, 8'h00);
    chk("R6 latched request served", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R6 vector 2", vec, 8'h32);
    eoi;
    set_irq(8'h00);
  endtask

  task automatic t_edge_hold;
    set_irq(8'h01);
    do_ack;
    chk("R8 vector 0", vec, 8'h30);
    eoi;
    chk("R8 held line no rerequest", {7'b0, int_w}, 8'h0);
    set_irq(8'h00);
    set_irq(8'h01);
    chk("R8 new edge", {7'b0, int_w}, 8'h1);
    do_ack;
    eoi;
    set_irq(8'h00);
  endtask

  task automatic t_spurious;
    do_ack;
    chk("R11 spurious vector", vec, 8'h37);
    chk("R11 spurious no int", {7'b0, int_w}, 8'h0);
  endtask

  task automatic t_same_cycle;
    set_irq(8'h10);
    do_ack;
    chk("R14 vector 4", vec, 8'h34);
    set_irq(8'h14);
    chk("R14 input 2 outranks 4", {7'b0, int_w}, 8'h1);
    @(negedge clk); ack = 1'b1; wr = 1'b1; a0 = 1'b0; wdata = 8'h20;
    @(negedge clk); ack = 1'b0; wr = 1'b0;
    chk("R14 vector 2", vec, 8'h32);
    set_irq(8'h34);
    chk("R14 input 2 in service", {7'b0, int_w}, 8'h0);
    eoi;
    chk("R14 input 4 already freed", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R14 vector 5", vec, 8'h35);
    eoi;
    set_irq(8'h00);
  endtask

  task automatic t_chain_level_aeoi;
    master = 1'b1;
    wr_reg(1'b0, 8'h19);
    wr_reg(1'b1, 8'h38);
    wr_reg(1'b1, 8'h04);
    wr_reg(1'b1, 8'h03);
    set_irq(8'h04);
    chk("R6 R2 chain word not a mask", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R3 vector 2 base 38", vec, 8'h3A);
    chk("R4 chained input yields vector", {7'b0, vec_en}, 8'h0);
    chk("R9 R13 level held re-asserts", {7'b0, int_w}, 8'h1);
    set_irq(8'h00);
    chk("R9 level dropped", {7'b0, int_w}, 8'h0);
    set_irq(8'h02);
    do_ack;
    chk("R4 plain input drives vector", {7'b0, vec_en}, 8'h1);
    chk("R5 vector 1", vec, 8'h39);
    set_irq(8'h22);
    do_ack;
    chk("R13 R7 input 1 again", vec, 8'h39);
    set_irq(8'h20);
    do_ack;
    chk("R9 vector 5", vec, 8'h3D);
    set_irq(8'h00);
  endtask

  task automatic t_slave_nomode;
    master = 1'b0;
    wr_reg(1'b0, 8'h10);
    wr_reg(1'b1, 8'h50);
    set_irq(8'h04);
    chk("R2 waits for chain word", {7'b0, int_w}, 8'h0);
    set_irq(8'h00);
    wr_reg(1'b1, 8'h02);
    set_irq(8'h04);
    chk("R2 ready without mode word", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R3 vector slave", vec, 8'h52);
    chk("R4 slave drives vector", {7'b0, vec_en}, 8'h1);
    set_irq(8'h44);
    chk("R5 normal eoi retained", {7'b0, int_w}, 8'h0);
    eoi;
    chk("R5 eoi frees", {7'b0, int_w}, 8'h1);
    do_ack;
    chk("R3 vector 6 slave", vec, 8'h56);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_setup_single;
    t_nesting;
    t_mask;
    t_edge_hold;
    t_spurious;
    t_same_cycle;
    t_chain_level_aeoi;
    t_slave_nomode;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule